// File: doc/BRIEF.md
# Dual-Source Selectable Clock Prescaler

This block produces the count-enable strobe for a downstream timer. A 14-bit binary divider chain provides power-of-two taps from base/2 up to base/16384. A 4-bit select field picks one of these taps. It can also pass the undivided base clock through, or stop the enable altogether. The base clock is the synchronous system clock by default. A mode input moves the timer onto a fast asynchronous peripheral clock instead.

Each base clock has its own copy of the divider. Only the copy matching the mode runs; the other is held cleared. A one-cycle write strobe clears the running divider, so software can start a fresh period. The strobe is edge-detected, so holding it high acts only once. The select field and clear request are registered in the system domain. They reach the fast domain through synchronizer stages. The enable is registered in the selected base domain and is always exactly one base cycle wide.

Top module: `dual_clk_prescaler`

## Requirements
- R1: While `rst_n` is low, `count_en` is low.
- R2: Select code 0 stops the prescaler: `count_en` stays low for as long as the code is held.
- R3: Select code 1 drives `count_en` high on every base clock cycle.
- R4: Select code n, for n from 2 to 15, makes `count_en` a pulse one base cycle wide. Consecutive pulses are exactly 2^(n-1) base cycles apart (2 for code 2 up to 16384 for code 15).
- R5: With `fast_mode` low, the base clock is `sys_clk`, and pulse spacing counts `sys_clk` cycles.
- R6: With `fast_mode` high, the base clock is `fast_clk`, and pulse spacing counts `fast_clk` cycles. The select and clear controls are synchronized into that domain before use.
- R7: In synchronous mode, take a rising `presc_clr` sampled at `sys_clk` edge A. The divider restarts from zero at edge A+1. With code n≥2, `count_en` stays low after edges A+1 through A+2^(n-1). It goes high after edge A+1+2^(n-1).
- R8: `presc_clr` acts only on its rising edge. Holding it high clears the divider once, and pulses then continue at the normal spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; base clock in synchronous mode; clocks the control inputs |
| fast_clk | input | 1 | Fast asynchronous peripheral clock; base clock in asynchronous mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects `fast_clk` as base clock, 0 selects `sys_clk` |
| presc_clr | input | 1 | Divider clear request, acts on its rising edge |
| clk_sel | input | SEL_W (4) | 0 stop, 1 undivided base, n≥2 base/2^(n-1) |
| count_en | output | 1 | One-base-cycle count-enable pulse for the downstream timer |

## Verification
The bench builds the block with its default parameters: a 4-bit select, and hence the full 14-bit chain with two synchronizer stages. This makes every select code reachable, up to divide-by-16384. All sixteen codes are swept in both clock modes. Pulse spacing is counted in the matching base clock and compared with 2^(n-1). The clear strobe is checked in synchronous mode against its exact restart latency. It is checked both as a single-cycle pulse and held high, which confirms the edge-only behaviour. A clear is also issued in fast mode, followed by a spacing check.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // Low-bit mask of the divider whose all-ones state marks the end of a tap period.
  // Codes 0 and 1 use no divider bits.
  function automatic logic [31:0] tap_mask(input logic [7:0] code);
    logic [31:0] m;
    if (code < 8'd2) m = '0;
    else             m = (32'd1 << (code - 8'd1)) - 32'd1;
    return m;
  endfunction
endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/psc_bit_sync.sv
module psc_bit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/psc_chain.sv
module psc_chain
  import psc_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter bit ASYNC       = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_tgl_i,
  output logic             en_o
);
  localparam int DIV_W  = (2 ** SEL_W) - 2;
  localparam int CTRL_W = SEL_W + 2;

  logic             run_c, tgl_c;
  logic [SEL_W-1:0] sel_c;

  if (ASYNC) begin : g_sync
    logic [CTRL_W-1:0] ctrl_s;
    psc_bit_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({run_i, sel_i, clr_tgl_i}),
      .q_o   (ctrl_s)
    );
    assign {run_c, sel_c, tgl_c} = ctrl_s;
  end else begin : g_direct
    assign run_c = run_i;
    assign sel_c = sel_i;
    assign tgl_c = clr_tgl_i;
  end

  logic [DIV_W-1:0] div_q, div_d;
  logic             en_q, en_d;
  logic             tgl_q;
  logic             clr, hit;
  logic [31:0]      mask32;
  logic [DIV_W-1:0] mask;

  always_comb begin
    clr    = tgl_c ^ tgl_q;
    mask32 = tap_mask(8'(sel_c));
    mask   = mask32[DIV_W-1:0];
    hit    = ((div_q & mask) == mask);
    if (!run_c || clr) div_d = '0;
    else               div_d = div_q + DIV_W'(1);
    en_d = run_c && !clr && (sel_c != '0) && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      en_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      en_q  <= en_d;
      tgl_q <= tgl_c;
    end
  end

  assign en_o = en_q;

  // R4: a running, uncleared divider advances by exactly one per base cycle
  a_r4_div_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_c && !clr |=> div_q == $past(div_q) + DIV_W'(1));
  // R2: stop code or idle chain yields no enable on the next cycle
  a_r2_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_c || sel_c == '0) |=> !en_q);
  // R4: with a divided tap held steady, an enable is never two cycles long
  a_r4_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && sel_c >= SEL_W'(2) && $stable(sel_c) |=> !en_q);
  // R7: a clear request restarts the divider at zero with the enable low
  a_r7_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_q == '0) && !en_q);
endmodule

// File: rtl/dual_clk_prescaler.sv
module dual_clk_prescaler #(
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             fast_clk,
  input  logic             rst_n,
  input  logic             fast_mode,
  input  logic             presc_clr,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             count_en
);
  localparam int N_DOM = 2;

  logic srst_sys_n, srst_fast_n;

  psc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(sys_clk), .rst_n(rst_n), .srst_n(srst_sys_n));
  psc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_fast (
    .clk(fast_clk), .rst_n(rst_n), .srst_n(srst_fast_n));

  // Clear request: rising edge flips a toggle that each chain edge-detects.
  logic clr_prev_q, clr_tgl_q, clr_rise;

  always_comb clr_rise = presc_clr && !clr_prev_q;

  always_ff @(posedge sys_clk or negedge srst_sys_n) begin
    if (!srst_sys_n) begin
      clr_prev_q <= 1'b0;
      clr_tgl_q  <= 1'b0;
    end else begin
      clr_prev_q <= presc_clr;
      if (clr_rise) clr_tgl_q <= !clr_tgl_q;
    end
  end

  logic [N_DOM-1:0] dom_en;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic dom_clk, dom_rst_n, dom_run;
    if (d == 0) begin : g_sys
      assign dom_clk   = sys_clk;
      assign dom_rst_n = srst_sys_n;
      assign dom_run   = !fast_mode;
    end else begin : g_fast
      assign dom_clk   = fast_clk;
      assign dom_rst_n = srst_fast_n;
      assign dom_run   = fast_mode;
    end
    psc_chain #(
      .SEL_W       (SEL_W),
      .ASYNC       (d != 0),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_chain (
      .clk       (dom_clk),
      .rst_n     (dom_rst_n),
      .run_i     (dom_run),
      .sel_i     (clk_sel),
      .clr_tgl_i (clr_tgl_q),
      .en_o      (dom_en[d])
    );
  end

  assign count_en = fast_mode ? dom_en[1] : dom_en[0];

  // R8: only a rising clear request flips the toggle
  a_r8_edge_toggle: assert property (@(posedge sys_clk) disable iff (!srst_sys_n)
    (presc_clr && $past(presc_clr)) |=> $stable(clr_tgl_q));
  // R1: output is quiet while the reset input is asserted
  always_comb a_r1_reset_quiet: assert (rst_n || !count_en);
endmodule

// File: tb/tb_dual_clk_prescaler.sv
`timescale 1ns/1ps
module tb_dual_clk_prescaler;
  localparam int SEL_W = 4;

  logic sys_clk = 1'b0, fast_clk = 1'b0;
  logic rst_n, fast_mode, presc_clr;
  logic [SEL_W-1:0] clk_sel;
  logic count_en;
  int checks = 0, failures = 0;

  always #2   sys_clk  = ~sys_clk;
  always #1.5 fast_clk = ~fast_clk;

  dual_clk_prescaler #(.SEL_W(SEL_W)) dut (
    .sys_clk(sys_clk), .fast_clk(fast_clk), .rst_n(rst_n),
    .fast_mode(fast_mode), .presc_clr(presc_clr),
    .clk_sel(clk_sel), .count_en(count_en));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit mode);
    if (mode) @(negedge fast_clk);
    else      @(negedge sys_clk);
  endtask

  // Sweep one code in one mode and check the pulse pattern (R2, R3, R4, R5, R6).
  task automatic sweep(input bit mode, input int code);
    string rq;
    int gap, ngaps, cnt, highs;
    bit seen;
    rq = mode ? "R6/R4" : "R5/R4";
    @(negedge sys_clk);
    clk_sel = SEL_W'(code);
    for (int i = 0; i < 16; i++) tick(mode);
    if (code == 0) begin
      highs = 0;
      for (int i = 0; i < 64; i++) begin tick(mode); if (count_en) highs++; end
      check(highs == 0, mode ? "R2/R6" : "R2/R5", highs, 0);
    end else if (code == 1) begin
      highs = 0;
      for (int i = 0; i < 32; i++) begin tick(mode); if (count_en) highs++; end
      check(highs == 32, mode ? "R3/R6" : "R3/R5", highs, 32);
    end else begin
      gap   = 1 << (code - 1);
      ngaps = (gap <= 256) ? 4 : 1;
      seen  = 1'b0;
      for (int i = 0; i < 2 * gap + 8 && !seen; i++) begin tick(mode); seen = count_en; end
      check(seen, rq, 0, 1);
      for (int g = 0; g < ngaps; g++) begin
        cnt = 0;
        do begin tick(mode); cnt++; end while (!count_en && cnt < 2 * gap + 8);
        check(cnt == gap, rq, cnt, gap);
      end
    end
  endtask

  // Synchronous-mode clear with code 4 (spacing 8); hold = cycles presc_clr stays high.
  task automatic clr_test(input int hold);
    int lows;
    @(negedge sys_clk);
    clk_sel = 4'd4;
    for (int i = 0; i < 20; i++) @(negedge sys_clk);
    presc_clr = 1'b1;
    lows = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge sys_clk);
      if (i == hold) presc_clr = 1'b0;
      if (i >= 2 && i <= 9 && !count_en) lows++;
      if (i == 10) check(count_en, "R7 first pulse after clear", int'(count_en), 1);
      if (hold > 1) begin
        if (i >= 11 && i <= 17) check(!count_en, "R8 no second clear", int'(count_en), 0);
        if (i == 18) check(count_en, "R8 spacing kept", int'(count_en), 1);
      end
    end
    check(lows == 8, "R7 quiet after clear", lows, 8);
    presc_clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; fast_mode = 1'b0; presc_clr = 1'b0; clk_sel = 4'd1;
    for (int i = 0; i < 5; i++) begin
      @(negedge sys_clk);
      check(!count_en, "R1 reset", int'(count_en), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) @(negedge sys_clk);

    for (int m = 0; m < 2; m++) begin
      @(negedge sys_clk);
      fast_mode = m[0];
      for (int c = 0; c < 16; c++) sweep(m[0], c);
    end

    @(negedge sys_clk);
    fast_mode = 1'b0;
    clr_test(1);
    clr_test(12);

    // Clear in fast mode, then spacing still correct (R6).
    @(negedge sys_clk);
    fast_mode = 1'b1;
    presc_clr = 1'b1;
    @(negedge sys_clk);
    presc_clr = 1'b0;
    sweep(1'b1, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(190000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule